// File: doc/BRIEF.md
# Status Word and Condition Check Unit

This block keeps the 32-bit status word of a CPU that runs in two modes: a privileged supervisor mode and an interruptible user mode. The low eight bits are control and flag bits whose positions other logic decodes. Bits 3:0 hold the ALU flags: zero at bit 0, carry at bit 1, negative at bit 2 and overflow at bit 3. Bit 4 is the sleep bit, bit 5 the interrupt-enable/user-mode bit, bit 6 the single-step bit and bit 7 the breakpoint-enable bit. Every bit above bit 7 simply holds what was last written to it. Software uses these upper bits as a trap number: it writes a nonzero value with bit 5 clear, and the supervisor reads it back.

Switching between modes only changes bit 5. An interrupt, a finished single step, or a break that is not routed to the external debugger clears bit 5, which returns the CPU to supervisor mode. The same unit also checks each instruction's 3-bit condition field against the current flags. It reports the mode and whether the CPU is waiting for an interrupt, fully halted, or stopped for an external debugger.

Top module: `status_flags_unit`

## Requirements
- R1: After reset the status word is all zeros: supervisor mode, no sleep, no debugger stop, and every status output low.
- R2: The condition output is combinational from `cond` and the current flags. Code 0 is always true. Code 1 is true when Z is set and code 2 when Z is clear. Code 3 is true when N is clear, code 4 when N and Z are both clear, and code 5 when N is set. Code 6 is true when C is set and code 7 when V is set.
- R3: An ALU flag update with no register write replaces bits 3:0 on the next cycle and leaves every other bit unchanged.
- R4: A privileged register write stores the whole word on the next cycle, including the bits above bit 7.
- R5: An unprivileged register write stores every bit except bits 6 and 7, which keep their previous values.
- R6: When a register write and an ALU flag update happen in the same cycle, the register write wins for all bits.
- R7: An interrupt while bit 5 is set clears bits 5, 4 and 6 on the next cycle. An interrupt while bit 5 is clear changes nothing.
- R8: A user-retire pulse while bits 5 and 6 are both set clears bits 5, 6 and 4 on the next cycle. The pulse has no effect when bit 6 is clear or when the CPU is in supervisor mode.
- R9: A break with bit 7 set raises `dbg_halt` in the same cycle and leaves the status word unchanged.
- R10: A break with bit 7 clear keeps `dbg_halt` low, and on the next cycle bit 6 is set and bit 5 is clear.
- R11: `sleeping` is high when bits 4 and 5 are both set. `halted` is high when bit 4 is set and bit 5 is clear.
- R12: `user_mode` follows bit 5 of the registered word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_flag_we | input | 1 | ALU flag update strobe |
| alu_flags | input | 4 | New flags {V,N,C,Z} |
| wr_en | input | 1 | Full register write strobe |
| wr_priv | input | 1 | Write issued from supervisor mode |
| wr_data | input | DATA_W | Register write data |
| irq | input | 1 | Interrupt request |
| brk | input | 1 | Break instruction reached |
| user_retire | input | 1 | One user-mode instruction completed |
| cond | input | 3 | Condition field to evaluate |
| sr_word | output | DATA_W | Registered status word |
| cond_true | output | 1 | Condition holds |
| user_mode | output | 1 | User mode, interrupts enabled |
| sleeping | output | 1 | Waiting for an interrupt |
| halted | output | 1 | Halted in supervisor mode |
| dbg_halt | output | 1 | Stopped for the external debugger |

## Verification
A corrupted status word shows up on `sr_word` one clock after the event that caused it, because the word is exposed directly. A wrongly merged write, flag update or trap event can therefore be seen before any later instruction hides it. A fault in the condition decode shows up on `cond_true` in the same cycle for the affected flag pattern. For that reason the bench sweeps every flag value against every condition code. A fault in the mode or step logic appears on `user_mode`, `sleeping` or `halted` one cycle after the interrupt, retire or break pulse that caused it.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int FLAG_W   = 4;
    localparam int POS_Z    = 0;
    localparam int POS_C    = 1;
    localparam int POS_N    = 2;
    localparam int POS_V    = 3;
    localparam int POS_SLP  = 4;
    localparam int POS_GIE  = 5;
    localparam int POS_STEP = 6;
    localparam int POS_BKEN = 7;

    typedef enum logic [2:0] {
        CC_ALWAYS = 3'd0,
        CC_EQ     = 3'd1,
        CC_NE     = 3'd2,
        CC_GE     = 3'd3,
        CC_GT     = 3'd4,
        CC_LT     = 3'd5,
        CC_CS     = 3'd6,
        CC_VS     = 3'd7
    } cond_e;

    typedef struct packed {
        logic v;
        logic n;
        logic c;
        logic z;
    } flags_t;
endpackage

// File: rtl/sr_cond_eval.sv
module sr_cond_eval
    import stat_pkg::*;
(
    input  logic [2:0] cond,
    input  flags_t     flags,
    output logic       hit
);
    always_comb begin
        unique case (cond_e'(cond))
            CC_ALWAYS: hit = 1'b1;
            CC_EQ:     hit = flags.z;
            CC_NE:     hit = !flags.z;
            CC_GE:     hit = !flags.n;
            CC_GT:     hit = !flags.n && !flags.z;
            CC_LT:     hit = flags.n;
            CC_CS:     hit = flags.c;
            CC_VS:     hit = flags.v;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/sr_state.sv
module sr_state
    import stat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_flag_we,
    input  logic [FLAG_W-1:0] alu_flags,
    input  logic              wr_en,
    input  logic              wr_priv,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq,
    input  logic              brk,
    input  logic              user_retire,
    output logic [DATA_W-1:0] word
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
    } sr_t;

    sr_t st_d, st_q;

    logic in_user_q, step_q, bken_q;
    assign in_user_q = st_q.word[POS_GIE];
    assign step_q    = st_q.word[POS_STEP];
    assign bken_q    = st_q.word[POS_BKEN];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.word = wr_data;
            if (!wr_priv) begin
                st_d.word[POS_STEP] = step_q;
                st_d.word[POS_BKEN] = bken_q;
            end
        end else if (alu_flag_we) begin
            st_d.word[FLAG_W-1:0] = alu_flags;
        end
        if (brk && !bken_q) begin
            st_d.word[POS_STEP] = 1'b1;
            st_d.word[POS_GIE]  = 1'b0;
        end else if (in_user_q && (irq || (user_retire && step_q))) begin
            st_d.word[POS_GIE]  = 1'b0;
            st_d.word[POS_STEP] = 1'b0;
            st_d.word[POS_SLP]  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.word;

    assert_irq_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && word[POS_GIE]) |=> (!word[POS_GIE] && !word[POS_SLP]));

    assert_step_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (user_retire && word[POS_GIE] && word[POS_STEP] && !brk) |=> (!word[POS_GIE] && !word[POS_STEP]));

    assert_user_wr_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv && !brk && !irq && !user_retire)
        |=> ($stable(word[POS_STEP]) && $stable(word[POS_BKEN])));

    assert_flag_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_flag_we && !wr_en && !brk && !irq && !user_retire)
        |=> (word[DATA_W-1:FLAG_W] == $past(word[DATA_W-1:FLAG_W])));

    assert_brk_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && !word[POS_BKEN]) |=> (word[POS_STEP] && !word[POS_GIE]));
endmodule

// File: rtl/sr_mode_out.sv
module sr_mode_out (
    input  logic slp,
    input  logic gie,
    input  logic bken,
    input  logic brk,
    output logic user_mode,
    output logic sleeping,
    output logic halted,
    output logic dbg_halt
);
    always_comb begin
        user_mode = gie;
        sleeping  = slp && gie;
        halted    = slp && !gie;
        dbg_halt  = brk && bken;
    end

    assert_sleep_excl_R11: assert final (!(sleeping && halted));
endmodule

// File: rtl/status_flags_unit.sv
module status_flags_unit
    import stat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_flag_we,
    input  logic [3:0]        alu_flags,
    input  logic              wr_en,
    input  logic              wr_priv,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq,
    input  logic              brk,
    input  logic              user_retire,
    input  logic [2:0]        cond,
    output logic [DATA_W-1:0] sr_word,
    output logic              cond_true,
    output logic              user_mode,
    output logic              sleeping,
    output logic              halted,
    output logic              dbg_halt
);
    flags_t cur_flags;

    sr_state #(.DATA_W(DATA_W)) u_state (
        .clk(clk), .rst_n(rst_n),
        .alu_flag_we(alu_flag_we), .alu_flags(alu_flags),
        .wr_en(wr_en), .wr_priv(wr_priv), .wr_data(wr_data),
        .irq(irq), .brk(brk), .user_retire(user_retire),
        .word(sr_word)
    );

    assign cur_flags = flags_t'(sr_word[FLAG_W-1:0]);

    sr_cond_eval u_cond (
        .cond(cond), .flags(cur_flags), .hit(cond_true)
    );

    sr_mode_out u_mode (
        .slp(sr_word[POS_SLP]), .gie(sr_word[POS_GIE]),
        .bken(sr_word[POS_BKEN]), .brk(brk),
        .user_mode(user_mode), .sleeping(sleeping),
        .halted(halted), .dbg_halt(dbg_halt)
    );

    assert_always_true_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 3'd0) |-> cond_true);

    assert_debug_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !wr_en && !alu_flag_we && !irq && !user_retire) |=> $stable(sr_word));
endmodule

// File: tb/status_flags_unit_test.sv
module status_flags_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alu_flag_we = 1'b0;
    logic [3:0]  alu_flags = '0;
    logic        wr_en = 1'b0, wr_priv = 1'b0;
    logic [31:0] wr_data = '0;
    logic        irq = 1'b0, brk = 1'b0, user_retire = 1'b0;
    logic [2:0]  cond = '0;
    logic [31:0] sr_word;
    logic        cond_true, user_mode, sleeping, halted, dbg_halt;
    int          n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    status_flags_unit uut (
        .clk(clk), .rst_n(rst_n), .alu_flag_we(alu_flag_we), .alu_flags(alu_flags),
        .wr_en(wr_en), .wr_priv(wr_priv), .wr_data(wr_data), .irq(irq), .brk(brk),
        .user_retire(user_retire), .cond(cond), .sr_word(sr_word), .cond_true(cond_true),
        .user_mode(user_mode), .sleeping(sleeping), .halted(halted), .dbg_halt(dbg_halt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
        alu_flag_we = 0; wr_en = 0; wr_priv = 0; irq = 0; brk = 0; user_retire = 0;
        #1;
    endtask

    task automatic pwrite(input logic [31:0] d);
        wr_en = 1; wr_priv = 1; wr_data = d;
        tick();
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1; #1;
        // R1 reset state
        chk("R1 word", sr_word, 32'h0);
        chk("R1 outs", {28'h0, user_mode, sleeping, halted, dbg_halt}, 32'h0);
        // R2 / R3 exhaustive flag x condition sweep
        for (int f = 0; f < 16; f++) begin
            alu_flag_we = 1; alu_flags = 4'(f);
            tick();
            chk("R3 flag update", sr_word, 32'(f));
            for (int c = 0; c < 8; c++) begin
                logic z, cy, ng, ov, e;
                z = f[0]; cy = f[1]; ng = f[2]; ov = f[3];
                case (c)
                    0: e = 1;  1: e = z;  2: e = !z;  3: e = !ng;
                    4: e = !ng && !z;  5: e = ng;  6: e = cy;  default: e = ov;
                endcase
                cond = 3'(c); #1;
                chk("R2 cond", {31'h0, cond_true}, {31'h0, e});
            end
        end
        // R3 upper bits kept
        pwrite(32'hABCD_0000);
        alu_flag_we = 1; alu_flags = 4'hF; tick();
        chk("R3 upper kept", sr_word, 32'hABCD_000F);
        // R4 privileged write
        pwrite(32'h1234_56C0);
        chk("R4 full write", sr_word, 32'h1234_56C0);
        // R5 unprivileged write keeps bits 6,7
        wr_en = 1; wr_priv = 0; wr_data = 32'h0000_0025; tick();
        chk("R5 user write", sr_word, 32'h0000_00E5);
        chk("R12 user mode", {31'h0, user_mode}, 32'h1);
        // R11 sleeping
        wr_en = 1; wr_priv = 0; wr_data = 32'h0000_0030; tick();
        chk("R11 sleeping", {30'h0, sleeping, halted}, 32'h2);
        // R7 interrupt in user mode
        irq = 1; tick();
        chk("R7 irq enter", sr_word, 32'h0000_0080);
        chk("R12 super mode", {31'h0, user_mode}, 32'h0);
        irq = 1; tick();
        chk("R7 irq ignored", sr_word, 32'h0000_0080);
        // R11 halted
        pwrite(32'h10);
        chk("R11 halted", {30'h0, sleeping, halted}, 32'h1);
        // R8 step completion and ignored cases
        pwrite(32'h60);
        user_retire = 1; tick();
        chk("R8 step done", sr_word, 32'h0);
        pwrite(32'h20);
        user_retire = 1; tick();
        chk("R8 no step", sr_word, 32'h20);
        pwrite(32'h40);
        user_retire = 1; tick();
        chk("R8 super", sr_word, 32'h40);
        // R9 break to debugger
        pwrite(32'hA0);
        brk = 1; #1;
        chk("R9 dbg_halt", {31'h0, dbg_halt}, 32'h1);
        tick();
        chk("R9 word kept", sr_word, 32'hA0);
        // R10 break as trap
        pwrite(32'h20);
        brk = 1; #1;
        chk("R10 no dbg", {31'h0, dbg_halt}, 32'h0);
        tick();
        chk("R10 trap", sr_word, 32'h40);
        // R6 write beats flag update
        wr_en = 1; wr_priv = 1; wr_data = 32'h100; alu_flag_we = 1; alu_flags = 4'hF;
        tick();
        chk("R6 write wins", sr_word, 32'h100);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule